// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register

This block is the digital front of a 10-bit digital-to-analog converter. An external master drives three wires: an active-low select, a serial clock and a data line. The block samples all three with a much faster system clock, moves bits into a 16-stage shift chain on serial-clock rises, and copies the converter code into a holding register when select is released. A one-cycle strobe marks each copy. The holding register's output drives the converter core.

A frame may carry 12 bits: ten code bits, most significant first, then two sub-LSB bits that are ignored. It may also carry 16 bits, where four dummy bits come before those twelve. In both cases the code is the ten bits received just before the last two. The stage that holds the oldest bit drives a cascade output on serial-clock falls. Several devices can then be chained with 16-bit frames, where each device passes on what it received sixteen clocks earlier.

The system clock must run at least four times faster than the serial clock. Select may change only while the serial clock is low.

Top module: `dac_serial_loader`

## Requirements
- R1: While rst_n is low at a rising edge of clk, the block clears dac_code to 0, clears code_update and cascade_sdo to 0, and clears the shift chain to all zeros.
- R2: Each serial-clock rise seen while select is low shifts the chain up by one place and puts dac_sdi into the bottom stage. The first bit sent therefore ends up in the most significant position.
- R3: Serial-clock edges seen while dac_cs_n is high leave the shift chain unchanged. This shows at the ports when a later select pulse with no clocks loads the same code as before.
- R4: On each rise of dac_cs_n, dac_code takes shift-chain bits 11 down to 2. For a 12-bit frame this is the first ten bits sent, and the last two bits are ignored.
- R5: A 16-bit frame whose first four bits are dummies loads the same code as the 12-bit frame made of its last twelve bits.
- R6: code_update is high for exactly one clk cycle per rise of dac_cs_n, in the same cycle that dac_code first shows the new value.
- R7: The frame length is not checked. A select rise after fewer than 12 serial clocks still loads bits 11 down to 2 of the chain, which then mixes older contents with the new bits.
- R8: On each serial-clock fall seen while select is low, cascade_sdo takes chain bit 15. A bit sent at serial rise k appears on cascade_sdo after fall k+15 and stays until the next fall.
- R9: cascade_sdo is 0 whenever dac_cs_n has been seen high, and the chain keeps its contents from one frame to the next.
- R10: Each input goes through two synchroniser flops. A change on an input first captured at clk edge p has its effect on the registered outputs at edge p+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dac_cs_n | input | 1 | Active-low frame select from the master |
| dac_sclk | input | 1 | Serial clock from the master |
| dac_sdi | input | 1 | Serial data in, most significant bit first |
| dac_code | output | 10 | Held converter code |
| code_update | output | 1 | One-cycle pulse when dac_code is reloaded |
| cascade_sdo | output | 1 | Cascade data out to the next device |

## Verification
A wrong bit in the shift chain stays hidden until one of two things happens. The next select rise copies it into dac_code, or, for the top stage, the next serial fall moves it onto cascade_sdo, which can be as soon as three system clocks later. A bad edge detector shows up as a misplaced or doubled code_update pulse, or as a chain shifted by one place, which makes a whole code read back doubled or halved. The behavioural model in the bench tracks the same synchroniser latency. Every output is compared on every clock, so any such fault is reported in the cycle where it first reaches a port.

// File: rtl/dac_loader_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the event bundle passed from the front end
// to the datapath. Assumes the frame layout of code bits then sub-LSB bits.
package dac_loader_pkg;
    localparam int CODE_W      = 10;
    localparam int SUB_W       = 2;
    localparam int FRAME_W     = 16;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic sel_rise;
        logic sel_idle;
        logic data;
    } serial_evt_t;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
// bit_sync: a WIDTH-wide chain of STAGES flops that brings asynchronous
// inputs into the clk domain. Each bit has its own reset value.
// Assumes: STAGES >= 1 and inputs slower than clk.
module bit_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d;
            end
        end else begin : g_next
            // Pass the value one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_frontend.sv
`timescale 1ns/1ps
// serial_frontend: synchronises select, serial clock and data, and finds
// edges by comparing each synchronised value with its value one cycle
// earlier. Assumes clk runs at least 4x the serial clock.
module serial_frontend
    import dac_loader_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_n,
    input  logic        sclk,
    input  logic        sdi,
    output serial_evt_t evt
);
    localparam logic [2:0] IDLE_VALS = 3'b010; // {sclk, sel_n, sdi}

    logic [2:0] synced;
    logic       sclk_prev;
    logic       sel_prev;

    bit_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(IDLE_VALS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sel_n, sdi}),
        .q     (synced)
    );

    // Keep last cycle's synchronised clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= IDLE_VALS[2];
            sel_prev  <= IDLE_VALS[1];
        end else begin
            sclk_prev <= synced[2];
            sel_prev  <= synced[1];
        end
    end

    // Build the event bundle from current and previous values.
    always_comb begin
        evt.sclk_rise = synced[2] & ~sclk_prev;
        evt.sclk_fall = ~synced[2] & sclk_prev;
        evt.sel_rise  = synced[1] & ~sel_prev;
        evt.sel_idle  = synced[1];
        evt.data      = synced[0];
    end

    a_r10_sel_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt.sel_rise |=> !evt.sel_rise);
endmodule

// File: rtl/frame_shifter.sv
`timescale 1ns/1ps
// frame_shifter: the serial shift chain and the cascade output. Bits enter
// at the bottom on serial rises while selected. The top stage goes to the
// cascade output on serial falls. Assumes events come from serial_frontend.
module frame_shifter
    import dac_loader_pkg::*;
#(
    parameter int WIDTH = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  serial_evt_t      evt,
    output logic [WIDTH-1:0] chain,
    output logic             cascade
);
    // Shift a bit in on each selected serial rise.
    always_ff @(posedge clk) begin
        if (!rst_n)                              chain <= '0;
        else if (evt.sclk_rise && !evt.sel_idle) chain <= {chain[WIDTH-2:0], evt.data};
    end

    // Drive the cascade from the top stage on falls; quiet when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)             cascade <= 1'b0;
        else if (evt.sel_idle)  cascade <= 1'b0;
        else if (evt.sclk_fall) cascade <= chain[WIDTH-1];
    end

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.sclk_rise && !evt.sel_idle) |=>
            (chain[0] == $past(evt.data)) && (chain[WIDTH-1:1] == $past(chain[WIDTH-2:0])));
    a_r3_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        evt.sel_idle |=> $stable(chain));
    a_r8_cascade_top: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.sclk_fall && !evt.sel_idle) |=> cascade == $past(chain[WIDTH-1]));
    a_r9_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        evt.sel_idle |=> !cascade);
endmodule

// File: rtl/code_holder.sv
`timescale 1ns/1ps
// code_holder: on a select rise, copies the code field (just above the
// sub-LSB bits) of the shift chain into the held register and pulses a
// strobe. Assumes the chain is at least CODE_W+SUB_W bits wide.
module code_holder
    import dac_loader_pkg::*;
#(
    parameter int CODE_WIDTH = CODE_W,
    parameter int SUB_WIDTH  = SUB_W,
    parameter int CHAIN_W    = FRAME_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  serial_evt_t           evt,
    input  logic [CHAIN_W-1:0]    chain,
    output logic [CODE_WIDTH-1:0] code,
    output logic                  update
);
    localparam int TOP = CODE_WIDTH + SUB_WIDTH - 1;

    // Load the code field and raise the strobe on select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code   <= '0;
            update <= 1'b0;
        end else begin
            update <= evt.sel_rise;
            if (evt.sel_rise) code <= chain[TOP:SUB_WIDTH];
        end
    end

    a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> !update);
    a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !update |-> $stable(code));
    a_r4_code_field: assert property (@(posedge clk) disable iff (!rst_n)
        update |-> code == $past(chain[TOP:SUB_WIDTH]));
endmodule

// File: rtl/dac_serial_loader.sv
`timescale 1ns/1ps
// dac_serial_loader: three-wire serial loader for a DAC code register.
// Front end synchronises the pins, the shifter collects frames and drives
// the cascade, the holder keeps the code. Assumes clk >= 4x serial clock
// and select changes only while the serial clock is low.
module dac_serial_loader
    import dac_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dac_cs_n,
    input  logic              dac_sclk,
    input  logic              dac_sdi,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_update,
    output logic              cascade_sdo
);
    serial_evt_t        evt;
    logic [FRAME_W-1:0] chain;

    serial_frontend #(.STAGES(SYNC_STAGES)) i_front (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (dac_cs_n),
        .sclk  (dac_sclk),
        .sdi   (dac_sdi),
        .evt   (evt)
    );

    frame_shifter #(.WIDTH(FRAME_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .chain   (chain),
        .cascade (cascade_sdo)
    );

    code_holder #(.CODE_WIDTH(CODE_W), .SUB_WIDTH(SUB_W), .CHAIN_W(FRAME_W)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .chain  (chain),
        .code   (dac_code),
        .update (code_update)
    );
endmodule

// File: tb/test_dac_serial_loader.sv
`timescale 1ns/1ps
module test_dac_serial_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dac_cs_n = 1'b1;
    logic       dac_sclk = 1'b0;
    logic       dac_sdi = 1'b0;
    logic [9:0] dac_code;
    logic       code_update;
    logic       cascade_sdo;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    bit model_live = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dac_serial_loader i_dac_serial_loader (
        .clk(clk), .rst_n(rst_n), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk),
        .dac_sdi(dac_sdi), .dac_code(dac_code), .code_update(code_update),
        .cascade_sdo(cascade_sdo)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: sampled-input history and a bit queue.
    bit   h_sclk[$], h_sel[$], h_sdi[$];
    bit   bits[$];
    logic [9:0] exp_code;
    logic exp_upd, exp_casc;

    always @(posedge clk) begin
        if (!rst_n) begin
            h_sclk = '{0, 0, 0}; h_sel = '{1, 1, 1}; h_sdi = '{0, 0, 0};
            bits = {};
            for (int i = 0; i < 16; i++) bits.push_back(1'b0);
            exp_code = '0; exp_upd = 1'b0; exp_casc = 1'b0;
        end else begin
            exp_upd = 1'b0;
            if (!h_sel[1] && h_sclk[1] && !h_sclk[0]) begin
                bits.push_back(h_sdi[1]);
                void'(bits.pop_front());
            end
            if (h_sel[1] && !h_sel[0]) begin
                for (int k = 0; k < 10; k++) exp_code[k] = bits[13-k];
                exp_upd = 1'b1;
            end
            if (h_sel[1]) exp_casc = 1'b0;
            else if (!h_sclk[1] && h_sclk[0]) exp_casc = bits[0];
            void'(h_sclk.pop_front()); void'(h_sel.pop_front()); void'(h_sdi.pop_front());
        end
        h_sclk.push_back(dac_sclk); h_sel.push_back(dac_cs_n); h_sdi.push_back(dac_sdi);
        if (h_sclk.size() > 3) begin
            void'(h_sclk.pop_front()); void'(h_sel.pop_front()); void'(h_sdi.pop_front());
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (model_live && !finished) begin
            check("R4/R10 code", dac_code, exp_code);
            check("R6/R10 strobe", code_update, exp_upd);
            check("R8/R10 cascade", cascade_sdo, exp_casc);
        end
        if (rst_n && code_update) strobes++;
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sel(logic v);
        dac_cs_n = v;
        wait_clk(4);
    endtask

    task automatic clock_bit(logic b);
        dac_sdi = b;  wait_clk(4);
        dac_sclk = 1; wait_clk(4);
        dac_sclk = 0; wait_clk(4);
    endtask

    task automatic send(int n, logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) clock_bit(v[i]);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] word_a;
        wait_clk(1);
        model_live = 1'b1;
        wait_clk(4);
        // R1: reset state
        check("R1 code", dac_code, 10'h0);
        check("R1 strobe/cascade", {code_update, cascade_sdo}, 2'b00);
        rst_n = 1'b1;
        wait_clk(4);

        // R2/R4/R6: 12-bit frame, code 0x2B5 then sub-LSB bits 11
        strobes = 0;
        set_sel(0); send(12, 12'hAD7); set_sel(1); wait_clk(4);
        check("R2 R4 12-bit code", dac_code, 10'h2B5);
        check("R6 one strobe", strobes, 1);

        // R5: 16-bit frame with dummies F, code 0x155, sub bits 01
        set_sel(0); send(16, 16'hF555); set_sel(1); wait_clk(4);
        check("R5 16-bit code", dac_code, 10'h155);

        // R3/R9: clocks while deselected are ignored, cascade stays low
        for (int i = 0; i < 5; i++) begin
            clock_bit(1'b1);
            check("R9 cascade low while idle", cascade_sdo, 1'b0);
        end
        strobes = 0;
        set_sel(0); set_sel(1); wait_clk(4);
        check("R3 chain kept across idle clocks", dac_code, 10'h155);
        check("R6 empty frame strobe", strobes, 1);

        // R7: short frame of 3 bits 101 on chain 0xF555 -> 0xAAAD
        set_sel(0); send(3, 3'b101); set_sel(1); wait_clk(4);
        check("R7 short frame code", dac_code, 10'h2AB);

        // R8: cascade delay of 16 falls
        word_a = 16'hC3A5;
        set_sel(0); send(16, {16'h0, word_a});
        for (int j = 0; j < 16; j++) begin
            check("R8 cascade bit", cascade_sdo, word_a[15-j]);
            clock_bit(1'b0);
        end
        set_sel(1); wait_clk(2);
        check("R9 cascade low after release", cascade_sdo, 1'b0);
        check("R4 zero code", dac_code, 10'h0);

        // R4: another 12-bit frame with all ones code, sub bits 00
        set_sel(0); send(12, 12'hFFC); set_sel(1); wait_clk(4);
        check("R4 all-ones code", dac_code, 10'h3FF);
        wait_clk(4);
        finish_run();
    end
endmodule